// File: doc/BRIEF.md
# Sigma-Delta Calibration Sequencer

This block sits on the host side of a single-bit sigma-delta modulator and runs one offset or one gain measurement on command. A start request from idle first holds the modulator in reset for a fixed number of clocks. It then raises one of two measurement lines, chosen by the request: the zero-select line for an offset run or the gain-select line for a gain run. The block discards a fixed number of bitstream beats while the modulator settles. It then counts the ones in a power-of-two window of beats and reports the count together with its signed distance from the ideal count.

The ideal ones density depends on the measurement and on the input mode latched at start. An offset run expects one half in bipolar mode and three eighths in unipolar mode. A gain run expects five eighths in either mode. A stored result is only meaningful for the input mode it was taken in, so the block flags it as stale whenever the live mode input differs from that mode.

The bitstream enters as a valid/ready stream. Each beat with valid high is one modulator clock. The modulator cannot be stalled, so back-pressure means discard: a beat offered while ready is low is dropped and has no effect. Ready is high only while beats are being consumed, during the settling and measuring phases. Control and result pins are plain levels, apart from a one-cycle done pulse.

Top module: `calseq_top`

## Requirements
- R1: While rst_n is low, and after it is released with no start, busy_o, done_o, mod_rst_o, zero_sel_o, gain_sel_o, bs_ready_o, res_valid_o and stale_o are all 0, and ones_cnt_o and dev_o are 0.
- R2: A start_i sampled high while idle drives mod_rst_o high for exactly RST_CYCLES clocks, beginning in the next cycle. Both select lines stay low while mod_rst_o is high.
- R3: After the reset phase, meas_sel_i as sampled with start selects the line: 0 (offset) raises zero_sel_o and 1 (gain) raises gain_sel_o. The line stays high through settling and measuring, later changes of meas_sel_i have no effect, and the two lines are never high together.
- R4: The first SETTLE_BEATS accepted beats after the select line rises are not counted.
- R5: The next 2^WIN_LOG2 accepted beats (valid high) are measured and ones_cnt_o reports how many carried a 1. Cycles with valid low are not counted, and beats after the window do not change the result.
- R6: dev_o is the signed value ones_cnt_o minus the ideal count. The ideal count is 2^WIN_LOG2 × 4/8 for offset in bipolar mode (bipolar_i=1), × 3/8 for offset in unipolar mode (bipolar_i=0), and × 5/8 for gain in either mode. The mode used is the one sampled with start.
- R7: done_o is high for exactly one cycle, in the cycle after the last window beat is accepted. ones_cnt_o and dev_o take their new values in that same cycle and change at no other time.
- R8: A start_i arriving while busy_o is high is ignored: the run continues with its original selection and mod_rst_o is not reasserted.
- R9: res_valid_o rises with the first done_o. stale_o is high exactly when res_valid_o is high and bipolar_i differs from the mode of the stored result.
- R10: bs_ready_o is high exactly while a select line is high (settling and measuring), and low in idle, reset and done.
- R11: busy_o is high from the cycle after an accepted start through the done cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Calibration request, sampled while idle |
| meas_sel_i | input | 1 | 0 = offset run, 1 = gain run |
| bipolar_i | input | 1 | Live input mode, 1 = bipolar, 0 = unipolar |
| bs_valid_i | input | 1 | Bitstream beat present |
| bs_bit_i | input | 1 | Bitstream bit value |
| bs_ready_o | output | 1 | Beat is consumed (settling or measuring) |
| mod_rst_o | output | 1 | Modulator reset control |
| zero_sel_o | output | 1 | Offset measurement select line |
| gain_sel_o | output | 1 | Gain measurement select line |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_valid_o | output | 1 | A result has been stored |
| stale_o | output | 1 | Stored result was taken in the other input mode |
| ones_cnt_o | output | WIN_LOG2+1 | Ones counted in the last window |
| dev_o | output | WIN_LOG2+2 | Signed count minus ideal count |

## Verification
The assertions assume start_i, meas_sel_i and bipolar_i are synchronous levels that are sampled at the clock edge. They also assume that a beat is a single cycle with bs_valid_i high, with no hold across cycles. The stimulus changes every input only at the falling edge. It inserts idle-valid gaps carrying a 1 on the bit line and keeps offering beats while ready is low, so discarded data would show up in the count. Mode and selection inputs are toggled during runs only where a requirement says they must be ignored or flagged.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RESET   = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_MEASURE = 3'd3,
    ST_DONE    = 3'd4
  } cal_state_e;

  typedef enum logic {
    MEAS_OFFSET = 1'b0,
    MEAS_GAIN   = 1'b1
  } meas_e;

  // Ideal ones density in eighths for a measurement and input mode.
  function automatic logic [3:0] ideal_eighths(input meas_e meas, input logic bipolar);
    logic [3:0] e;
    if (meas == MEAS_GAIN)  e = 4'd5;
    else if (bipolar)       e = 4'd4;
    else                    e = 4'd3;
    return e;
  endfunction

endpackage

// File: rtl/calseq_beat_cnt.sv
module calseq_beat_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (en_i) begin
      if (cnt_q == TOP)    cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = en_i && (cnt_q == TOP);
endmodule

// File: rtl/calseq_ones_acc.sv
module calseq_ones_acc #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          bit_i,
  output logic [CW-1:0] sum_next_o
);
  logic [CW-1:0] acc_q;

  always_comb begin
    sum_next_o = acc_q;
    if (en_i) sum_next_o = acc_q + CW'(bit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else             acc_q <= sum_next_o;
  end
endmodule

// File: rtl/calseq_ideal.sv
module calseq_ideal
  import calseq_pkg::*;
#(
  parameter int WIN_LOG2 = 10
) (
  input  meas_e                meas_i,
  input  logic                 bipolar_i,
  output logic [WIN_LOG2:0]    ideal_o
);
  localparam int IW = WIN_LOG2 + 4;

  logic [3:0]    eighths;
  logic [IW-1:0] scaled;

  assign eighths = ideal_eighths(meas_i, bipolar_i);

  generate
    if (WIN_LOG2 >= 3) begin : g_exact
      assign scaled  = IW'(eighths) << WIN_LOG2;
      assign ideal_o = scaled[IW-1:3];
    end else begin : g_round
      // Short windows: round the density product to nearest.
      assign scaled  = (IW'(eighths) << WIN_LOG2) + IW'(4);
      assign ideal_o = scaled[IW-1:3];
    end
  endgenerate
endmodule

// File: rtl/calseq_fsm.sv
module calseq_fsm
  import calseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       meas_sel_i,
  input  logic       bipolar_i,
  input  logic       rst_last_i,
  input  logic       settle_last_i,
  input  logic       win_last_i,
  output cal_state_e state_o,
  output meas_e      meas_o,
  output logic       mode_o
);
  cal_state_e state_q, state_d;
  meas_e      meas_q;
  logic       mode_q;
  logic       accept;

  assign accept = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept)        state_d = ST_RESET;
      ST_RESET:   if (rst_last_i)    state_d = ST_SETTLE;
      ST_SETTLE:  if (settle_last_i) state_d = ST_MEASURE;
      ST_MEASURE: if (win_last_i)    state_d = ST_DONE;
      ST_DONE:                       state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      meas_q  <= MEAS_OFFSET;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        meas_q <= meas_e'(meas_sel_i);
        mode_q <= bipolar_i;
      end
    end
  end

  assign state_o = state_q;
  assign meas_o  = meas_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/calseq_top.sv
module calseq_top
  import calseq_pkg::*;
#(
  parameter int WIN_LOG2     = 10,
  parameter int SETTLE_BEATS = 1000,
  parameter int RST_CYCLES   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  meas_sel_i,
  input  logic                  bipolar_i,
  input  logic                  bs_valid_i,
  input  logic                  bs_bit_i,
  output logic                  bs_ready_o,
  output logic                  mod_rst_o,
  output logic                  zero_sel_o,
  output logic                  gain_sel_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  res_valid_o,
  output logic                  stale_o,
  output logic [WIN_LOG2:0]     ones_cnt_o,
  output logic signed [WIN_LOG2+1:0] dev_o
);
  localparam int CW  = WIN_LOG2 + 1;
  localparam int WIN = 1 << WIN_LOG2;

  cal_state_e state;
  meas_e      meas;
  logic       mode;
  logic       rst_last, settle_last, win_last;
  logic       idle, in_rst, in_settle, in_meas, in_done, sel_on;
  logic       beat;
  logic [CW-1:0] sum_next, ideal;
  logic signed [CW:0] dev_next;

  logic [CW-1:0]      ones_q;
  logic signed [CW:0] dev_q;
  logic               have_q, res_mode_q;

  calseq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .meas_sel_i    (meas_sel_i),
    .bipolar_i     (bipolar_i),
    .rst_last_i    (rst_last),
    .settle_last_i (settle_last),
    .win_last_i    (win_last),
    .state_o       (state),
    .meas_o        (meas),
    .mode_o        (mode)
  );

  assign idle      = (state == ST_IDLE);
  assign in_rst    = (state == ST_RESET);
  assign in_settle = (state == ST_SETTLE);
  assign in_meas   = (state == ST_MEASURE);
  assign in_done   = (state == ST_DONE);
  assign sel_on    = in_settle || in_meas;
  assign beat      = bs_valid_i && sel_on;

  calseq_beat_cnt #(.LIMIT(RST_CYCLES)) u_rst_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(idle), .en_i(in_rst), .last_o(rst_last)
  );

  calseq_beat_cnt #(.LIMIT(SETTLE_BEATS)) u_settle_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(idle), .en_i(beat && in_settle), .last_o(settle_last)
  );

  calseq_beat_cnt #(.LIMIT(WIN)) u_win_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(idle), .en_i(beat && in_meas), .last_o(win_last)
  );

  calseq_ones_acc #(.CW(CW)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (idle),
    .en_i       (beat && in_meas),
    .bit_i      (bs_bit_i),
    .sum_next_o (sum_next)
  );

  calseq_ideal #(.WIN_LOG2(WIN_LOG2)) u_ideal (
    .meas_i    (meas),
    .bipolar_i (mode),
    .ideal_o   (ideal)
  );

  assign dev_next = $signed({1'b0, sum_next}) - $signed({1'b0, ideal});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q     <= '0;
      dev_q      <= '0;
      have_q     <= 1'b0;
      res_mode_q <= 1'b0;
    end else if (win_last) begin
      ones_q     <= sum_next;
      dev_q      <= dev_next;
      have_q     <= 1'b1;
      res_mode_q <= mode;
    end
  end

  assign bs_ready_o  = sel_on;
  assign mod_rst_o   = in_rst;
  assign zero_sel_o  = sel_on && (meas == MEAS_OFFSET);
  assign gain_sel_o  = sel_on && (meas == MEAS_GAIN);
  assign busy_o      = !idle;
  assign done_o      = in_done;
  assign res_valid_o = have_q;
  assign stale_o     = have_q && (bipolar_i != res_mode_q);
  assign ones_cnt_o  = ones_q;
  assign dev_o       = dev_q;
endmodule

// File: rtl/calseq_chk.sv
module calseq_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mod_rst_o,
  input logic          zero_sel_o,
  input logic          gain_sel_o,
  input logic          bs_ready_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          res_valid_o,
  input logic          stale_o,
  input logic [CW-1:0] ones_cnt_o
);
  p_sel_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_sel_o && gain_sel_o));

  p_rst_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst_o |-> (!zero_sel_o && !gain_sel_o));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ones_cnt_o) |-> done_o);

  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_rst_o) |-> $past(!busy_o));

  p_ready_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bs_ready_o |-> (zero_sel_o || gain_sel_o));

  p_stale_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stale_o |-> res_valid_o);

  p_busy_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_rst_o || zero_sel_o || gain_sel_o || done_o) |-> busy_o);
endmodule

bind calseq_top calseq_chk #(.CW(WIN_LOG2 + 1)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mod_rst_o   (mod_rst_o),
  .zero_sel_o  (zero_sel_o),
  .gain_sel_o  (gain_sel_o),
  .bs_ready_o  (bs_ready_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .res_valid_o (res_valid_o),
  .stale_o     (stale_o),
  .ones_cnt_o  (ones_cnt_o)
);

// File: tb/calseq_top_test.sv
module calseq_top_test;
  localparam int WL  = 4;
  localparam int WIN = 1 << WL;
  localparam int SB  = 6;
  localparam int RC  = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start_i, meas_sel_i, bipolar_i, bs_valid_i, bs_bit_i;
  logic bs_ready_o, mod_rst_o, zero_sel_o, gain_sel_o, busy_o, done_o;
  logic res_valid_o, stale_o;
  logic [WL:0] ones_cnt_o;
  logic signed [WL+1:0] dev_o;

  int checks = 0;
  int fails  = 0;

  calseq_top #(.WIN_LOG2(WL), .SETTLE_BEATS(SB), .RST_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .meas_sel_i(meas_sel_i),
    .bipolar_i(bipolar_i), .bs_valid_i(bs_valid_i), .bs_bit_i(bs_bit_i),
    .bs_ready_o(bs_ready_o), .mod_rst_o(mod_rst_o), .zero_sel_o(zero_sel_o),
    .gain_sel_o(gain_sel_o), .busy_o(busy_o), .done_o(done_o),
    .res_valid_o(res_valid_o), .stale_o(stale_o), .ones_cnt_o(ones_cnt_o),
    .dev_o(dev_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ideal_of(input int meas, input int bip);
    int e;
    e = (meas == 1) ? 5 : (bip == 1 ? 4 : 3);
    return (WIN * e) / 8;
  endfunction

  task automatic run_cal(input int meas, input int bip, input int k,
                         input bit gap, input bit poke, input bit flip);
    int n;
    int exp_ideal;
    exp_ideal = ideal_of(meas, bip);
    @(negedge clk);
    start_i = 1'b1; meas_sel_i = meas[0]; bipolar_i = bip[0];
    @(negedge clk);
    start_i = 1'b0; meas_sel_i = ~meas[0];
    chk(busy_o == 1'b1, "R11", "busy after start", int'(busy_o), 1);
    n = 0;
    while (mod_rst_o && n < 50) begin
      chk(!zero_sel_o && !gain_sel_o, "R2", "select during reset",
          int'({zero_sel_o, gain_sel_o}), 0);
      chk(bs_ready_o == 1'b0, "R10", "ready during reset", int'(bs_ready_o), 0);
      n++;
      @(negedge clk);
    end
    chk(n == RC, "R2", "reset length", n, RC);
    chk(zero_sel_o == (meas == 0) && gain_sel_o == (meas == 1), "R3",
        "select line", int'({zero_sel_o, gain_sel_o}), (meas == 0) ? 2 : 1);
    chk(bs_ready_o == 1'b1, "R10", "ready in settle", int'(bs_ready_o), 1);
    for (int i = 0; i < SB; i++) begin
      if (gap) begin
        bs_valid_i = 1'b0; bs_bit_i = 1'b1;
        @(negedge clk);
      end
      bs_valid_i = 1'b1; bs_bit_i = (i % 2 == 0);  // R4: these ones must not count
      @(negedge clk);
    end
    for (int i = 0; i < WIN; i++) begin
      if (gap && (i % 3 == 0)) begin
        bs_valid_i = 1'b0; bs_bit_i = 1'b1;
        @(negedge clk);
      end
      bs_valid_i = 1'b1; bs_bit_i = (i < k);
      if (poke && i == 1) begin start_i = 1'b1; meas_sel_i = ~meas[0]; end
      if (flip && i == 2) bipolar_i = ~bip[0];
      @(negedge clk);
      start_i = 1'b0;
      if (i < WIN - 1)
        chk(!(zero_sel_o && gain_sel_o) && busy_o && !mod_rst_o, "R8",
            "run undisturbed", int'({zero_sel_o, gain_sel_o, mod_rst_o}), 0);
    end
    chk(done_o == 1'b1, "R7", "done after window", int'(done_o), 1);
    chk(int'(ones_cnt_o) == k, "R5", "ones count", int'(ones_cnt_o), k);
    chk(int'(dev_o) == k - exp_ideal, "R6", "deviation", int'(dev_o), k - exp_ideal);
    chk(!zero_sel_o && !gain_sel_o && !bs_ready_o, "R10", "lines down at done",
        int'({zero_sel_o, gain_sel_o, bs_ready_o}), 0);
    bs_valid_i = 1'b1; bs_bit_i = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0, "R7", "done one cycle", int'(done_o), 0);
    chk(busy_o == 1'b0, "R11", "idle after done", int'(busy_o), 1'b0);
    chk(int'(ones_cnt_o) == k, "R5", "count held after window", int'(ones_cnt_o), k);
    chk(res_valid_o == 1'b1, "R9", "result valid", int'(res_valid_o), 1);
    chk(stale_o == flip, "R9", "stale after run", int'(stale_o), int'(flip));
    bs_valid_i = 1'b0; bs_bit_i = 1'b0;
    @(negedge clk);
    chk(mod_rst_o == 1'b0 && busy_o == 1'b0, "R8", "no second run",
        int'({mod_rst_o, busy_o}), 0);
    bipolar_i = bip[0];
  endtask

  initial begin
    #(100_000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; meas_sel_i = 1'b0; bipolar_i = 1'b1;
    bs_valid_i = 1'b1; bs_bit_i = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, mod_rst_o, zero_sel_o, gain_sel_o, bs_ready_o,
         res_valid_o, stale_o} == 8'd0 && ones_cnt_o == '0 && dev_o == '0,
        "R1", "outputs in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy_o, mod_rst_o, zero_sel_o, gain_sel_o, bs_ready_o, res_valid_o} == 6'd0,
        "R1", "idle without start", int'(mod_rst_o), 0);
    bs_valid_i = 1'b0;

    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 2; b++)
        for (int k = 0; k <= WIN; k++)
          run_cal(m, b, k, k % 2 == 1, k == 5, 1'b0);

    run_cal(0, 1, 9, 1'b1, 1'b0, 1'b1);
    run_cal(0, 0, 4, 1'b0, 1'b1, 1'b1);

    @(negedge clk);
    bipolar_i = 1'b1; #1;
    chk(stale_o == 1'b1, "R9", "mode differs from result", int'(stale_o), 1);
    bipolar_i = 1'b0; #1;
    chk(stale_o == 1'b0, "R9", "mode matches result", int'(stale_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule